// File: doc/BRIEF.md
# I/O Card Bus Front End: Address Decode, Wait Stretch and IRQ Gate

This block sits between an 8-bit, ISA-style I/O bus and the registers of a plug-in I/O card. It takes the bus address and the read and write strobes. It compares the address against a base that is set with switches, and then raises one of two chip selects. One select is for a four-register parallel-port window. The other is for an optional four-register counter/timer window placed directly above it. Both selects come with the two-bit register offset inside the window.

A jumper can ask for slow accesses. In that case the block pulls channel-ready low for a set number of bus clocks at the start of each access that hits the card. Other bus cycles are never held up.

The block also passes an external interrupt request onto the bus. The request is a rising-edge source, and the block drives it through a buffer onto one of six bus IRQ levels (2 to 7), chosen by a routing code. The line is driven only while the active-low interrupt-enable pin is low. When the pin is unconnected it must be tied high on the board, which leaves the interrupt disabled. In every other case each IRQ line is released, which is shown here as a low output-enable.

Top module: `isa_card_front`

## Requirements
- R1: With a read (`ior_n`=0) or write (`iow_n`=0) strobe active and `aen`=0, an address from B to B+3 sets `pio_sel`=1 and `reg_off`=address−B. Here B = `base_sw`×4.
- R2: When `HAS_CTR`=1, an address from B+4 to B+7 sets `ctr_sel`=1 and `reg_off`=address−B−4 under the same strobe conditions. When `HAS_CTR`=0, `ctr_sel` stays 0 and those addresses select nothing.
- R3: No select is raised, and `reg_off` is 0, in any of these cases: the address is outside the card's window (including below B, or past the top of the 10-bit space); neither strobe is active; or `aen`=1.
- R4: Bit i of `base_sw` equal to 1 (switch down) means the card responds only when address bit i+2 is 1. The factory setting `base_sw`=8'hC0 places the card at 0x300.
- R5: With `wait_en`=0, `chrdy` is 1 in every cycle.
- R6: With `wait_en`=1, an access that selects the card holds `chrdy` at 0 for exactly `WAIT_CLKS` bus clocks. The count starts with the clock in which the strobe first selects the card. After that, `chrdy` returns to 1 even if the strobe is still held. A new access starts a new count.
- R7: A strobed bus cycle that does not select the card never drives `chrdy` low, even with `wait_en`=1.
- R8: With `irq_en_n`=1, every bit of `irq_oe` is 0.
- R9: With `irq_en_n`=0 and `irq_route` from 2 to 7, exactly `irq_oe[irq_route-2]` is 1. The matching `irq_line` bit follows `irq_src` in the same cycle.
- R10: A routing code of 0 or 1 means "no level", and `irq_oe` is then 0.
- R11: After reset, with idle bus inputs, both selects are 0 and `chrdy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 10 | Bus I/O address |
| ior_n | input | 1 | Read strobe, active low |
| iow_n | input | 1 | Write strobe, active low |
| aen | input | 1 | DMA address-enable; 1 blocks decode |
| base_sw | input | 8 | Base switches for address bits 9..2, 1 = down |
| wait_en | input | 1 | Wait-state jumper |
| irq_src | input | 1 | External interrupt request |
| irq_en_n | input | 1 | Interrupt enable, active low |
| irq_route | input | 3 | IRQ level code 2..7; 0 or 1 = none |
| pio_sel | output | 1 | Parallel-port window select |
| ctr_sel | output | 1 | Counter window select |
| reg_off | output | 2 | Register offset inside the selected window |
| chrdy | output | 1 | Channel ready; 0 stretches the cycle |
| irq_line | output | 6 | Buffered interrupt value for levels 2..7 |
| irq_oe | output | 6 | Drive enable for each IRQ level |

## Verification
The assertions check four rules on every cycle:
- the two selects are never raised together;
- `chrdy` drops only while the card is selected and the jumper is set;
- the first cycle of every card access is stretched;
- IRQ drive is one-hot and never on while the enable pin is high.

The bench scenarios are needed for the parts that depend on exact values and timing:
- the exact window edges, including the bottom of the address space and wrap past its top;
- the switch-to-address mapping;
- the length of the stretch and its restart on a new access;
- the level chosen by each routing code.

// File: rtl/isa_card_front.sv
module isa_card_front #(
  parameter int ADDR_W    = 10,
  parameter int WAIT_CLKS = 1,
  parameter bit HAS_CTR   = 1'b1,
  parameter int NLEV      = 6,
  parameter int LEV_BASE  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic              aen,
  input  logic [ADDR_W-3:0] base_sw,
  input  logic              wait_en,
  input  logic              irq_src,
  input  logic              irq_en_n,
  input  logic [2:0]        irq_route,
  output logic              pio_sel,
  output logic              ctr_sel,
  output logic [1:0]        reg_off,
  output logic              chrdy,
  output logic [NLEV-1:0]   irq_line,
  output logic [NLEV-1:0]   irq_oe
);
  localparam int CW  = $clog2(WAIT_CLKS + 1);
  localparam int BLK = ADDR_W - 2;

  logic [ADDR_W:0]  diff;
  logic             below;
  logic [BLK-1:0]   blk;
  logic             strobe;
  logic             pio_hit;
  logic             ctr_hit;
  logic             any_sel;
  logic             sel_q;
  logic             start;
  logic [CW-1:0]    wcnt;

  assign diff    = {1'b0, addr} - {1'b0, base_sw, 2'b00};
  assign below   = diff[ADDR_W];
  assign blk     = diff[ADDR_W-1:2];
  assign strobe  = (~ior_n | ~iow_n) & ~aen;
  assign pio_hit = ~below && (blk == '0);

  generate
    if (HAS_CTR) begin : g_ctr
      assign ctr_hit = ~below && (blk == BLK'(1));
    end else begin : g_noctr
      assign ctr_hit = 1'b0;
    end
  endgenerate

  assign pio_sel = strobe & pio_hit;
  assign ctr_sel = strobe & ctr_hit;
  assign any_sel = pio_sel | ctr_sel;
  assign reg_off = any_sel ? diff[1:0] : 2'b00;

  assign start = any_sel & ~sel_q;
  assign chrdy = ~(wait_en & any_sel & (start | (wcnt != '0)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      wcnt  <= '0;
    end else begin
      sel_q <= any_sel;
      if (!any_sel)
        wcnt <= '0;
      else if (start)
        wcnt <= CW'(WAIT_CLKS - 1);
      else if (wcnt != '0)
        wcnt <= wcnt - 1'b1;
    end
  end

  genvar i;
  generate
    for (i = 0; i < NLEV; i++) begin : g_lev
      assign irq_line[i] = irq_src;
      assign irq_oe[i]   = ~irq_en_n && (irq_route == 3'(i + LEV_BASE));
    end
  endgenerate

  assert_sel_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pio_sel, ctr_sel}));

  assert_rdy_only_card_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !chrdy |-> (any_sel && wait_en));

  assert_rdy_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_en |-> chrdy);

  assert_first_stretch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(any_sel) && wait_en) |-> !chrdy);

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en_n |-> (irq_oe == '0));

  assert_irq_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_oe));
endmodule

// File: tb/isa_card_front_bench.sv
module isa_card_front_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] addr = '0;
  logic ior_n = 1'b1, iow_n = 1'b1, aen = 1'b0;
  logic [7:0] base_sw = 8'hC0;
  logic wait_en = 1'b0, irq_src = 1'b0, irq_en_n = 1'b1;
  logic [2:0] irq_route = 3'd0;
  logic pio_sel, ctr_sel, chrdy, pio2, ctr2, chrdy2;
  logic [1:0] reg_off, off2;
  logic [5:0] irq_line, irq_oe, line2, oe2;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  isa_card_front #(.WAIT_CLKS(3), .HAS_CTR(1'b1)) u_isa_card_front (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ior_n(ior_n), .iow_n(iow_n), .aen(aen),
    .base_sw(base_sw), .wait_en(wait_en), .irq_src(irq_src), .irq_en_n(irq_en_n),
    .irq_route(irq_route), .pio_sel(pio_sel), .ctr_sel(ctr_sel), .reg_off(reg_off),
    .chrdy(chrdy), .irq_line(irq_line), .irq_oe(irq_oe));

  isa_card_front #(.WAIT_CLKS(1), .HAS_CTR(1'b0)) u_isa_card_front_noctr (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ior_n(ior_n), .iow_n(iow_n), .aen(aen),
    .base_sw(base_sw), .wait_en(wait_en), .irq_src(irq_src), .irq_en_n(irq_en_n),
    .irq_route(irq_route), .pio_sel(pio2), .ctr_sel(ctr2), .reg_off(off2),
    .chrdy(chrdy2), .irq_line(line2), .irq_oe(oe2));

  // fields: base_sw, addr, {ior_n, iow_n, aen}, {pio, ctr}, offset
  localparam logic [24:0] TBL [0:15] = '{
    {8'hC0, 10'h300, 3'b010, 2'b10, 2'd0},
    {8'hC0, 10'h303, 3'b100, 2'b10, 2'd3},
    {8'hC0, 10'h304, 3'b010, 2'b01, 2'd0},
    {8'hC0, 10'h307, 3'b100, 2'b01, 2'd3},
    {8'hC0, 10'h308, 3'b010, 2'b00, 2'd0},
    {8'hC0, 10'h2FF, 3'b010, 2'b00, 2'd0},
    {8'hC0, 10'h301, 3'b110, 2'b00, 2'd0},
    {8'hC0, 10'h302, 3'b011, 2'b00, 2'd0},
    {8'h01, 10'h004, 3'b010, 2'b10, 2'd0},
    {8'h01, 10'h00A, 3'b100, 2'b01, 2'd2},
    {8'h01, 10'h000, 3'b010, 2'b00, 2'd0},
    {8'hFF, 10'h3FC, 3'b100, 2'b10, 2'd0},
    {8'hFF, 10'h3FF, 3'b010, 2'b10, 2'd3},
    {8'hFF, 10'h000, 3'b010, 2'b00, 2'd0},
    {8'h00, 10'h002, 3'b010, 2'b10, 2'd2},
    {8'h00, 10'h005, 3'b100, 2'b01, 2'd1}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic bus(input logic [9:0] a, input logic r, input logic w, input logic e);
    @(negedge clk);
    addr = a; ior_n = r; iow_n = w; aen = e;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R11 pio_sel in reset", int'(pio_sel), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R11 pio_sel idle", int'(pio_sel), 0);
    check("R11 ctr_sel idle", int'(ctr_sel), 0);
    check("R11 chrdy idle", int'(chrdy), 1);

    // R1 R2 R3 R4 R5 decode table, wait jumper off
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      base_sw = TBL[k][24:17];
      bus(TBL[k][16:7], TBL[k][6], TBL[k][5], TBL[k][4]);
      check($sformatf("R1/R4 pio_sel vec%0d", k), int'(pio_sel), int'(TBL[k][3]));
      check($sformatf("R2 ctr_sel vec%0d", k), int'(ctr_sel), int'(TBL[k][2]));
      check($sformatf("R3 reg_off vec%0d", k), int'(reg_off), int'(TBL[k][1:0]));
      check($sformatf("R5 chrdy vec%0d", k), int'(chrdy), 1);
      bus(10'h000, 1'b1, 1'b1, 1'b0);
    end

    // R2: no counter window on the plain variant
    base_sw = 8'hC0;
    bus(10'h305, 1'b0, 1'b1, 1'b0);
    check("R2 noctr ctr_sel", int'(ctr2), 0);
    check("R2 noctr pio_sel", int'(pio2), 0);
    check("R3 noctr reg_off", int'(off2), 0);
    bus(10'h301, 1'b0, 1'b1, 1'b0);
    check("R1 noctr pio_sel", int'(pio2), 1);
    bus(10'h000, 1'b1, 1'b1, 1'b0);

    // R6 stretch of three clocks, then release while strobe held
    wait_en = 1'b1;
    bus(10'h302, 1'b0, 1'b1, 1'b0);
    check("R6 chrdy cycle0", int'(chrdy), 0);
    check("R6 noctr chrdy cycle0", int'(chrdy2), 0);
    @(negedge clk); #1;
    check("R6 chrdy cycle1", int'(chrdy), 0);
    check("R6 noctr chrdy cycle1", int'(chrdy2), 1);
    @(negedge clk); #1;
    check("R6 chrdy cycle2", int'(chrdy), 0);
    @(negedge clk); #1;
    check("R6 chrdy cycle3", int'(chrdy), 1);
    @(negedge clk); #1;
    check("R6 chrdy held strobe", int'(chrdy), 1);
    bus(10'h302, 1'b1, 1'b1, 1'b0);
    check("R6 chrdy idle", int'(chrdy), 1);
    bus(10'h306, 1'b1, 1'b0, 1'b0);
    check("R6 restart cycle0", int'(chrdy), 0);
    bus(10'h306, 1'b1, 1'b1, 1'b0);
    check("R6 early end", int'(chrdy), 1);
    bus(10'h306, 1'b1, 1'b0, 1'b0);
    check("R6 restart after short", int'(chrdy), 0);
    bus(10'h000, 1'b1, 1'b1, 1'b0);

    // R7 other cycles not stretched
    bus(10'h200, 1'b0, 1'b1, 1'b0);
    check("R7 foreign read", int'(chrdy), 1);
    bus(10'h300, 1'b0, 1'b1, 1'b1);
    check("R7 dma cycle", int'(chrdy), 1);
    bus(10'h000, 1'b1, 1'b1, 1'b0);
    wait_en = 1'b0;

    // R8 R9 R10 interrupt gate
    @(negedge clk);
    irq_en_n = 1'b1; irq_route = 3'd5; irq_src = 1'b1; #1;
    check("R8 oe disabled", int'(irq_oe), 0);
    irq_en_n = 1'b0; #1;
    check("R9 oe level5", int'(irq_oe), 6'b001000);
    check("R9 line level5 high", int'(irq_line[3]), 1);
    irq_src = 1'b0; #1;
    check("R9 line level5 low", int'(irq_line[3]), 0);
    irq_route = 3'd2; #1;
    check("R9 oe level2", int'(irq_oe), 6'b000001);
    irq_route = 3'd7; #1;
    check("R9 oe level7", int'(irq_oe), 6'b100000);
    irq_route = 3'd0; #1;
    check("R10 route0", int'(irq_oe), 0);
    irq_route = 3'd1; #1;
    check("R10 route1", int'(irq_oe), 0);

    // R11 reset mid-stretch
    wait_en = 1'b1;
    bus(10'h300, 1'b0, 1'b1, 1'b0);
    bus(10'h000, 1'b1, 1'b1, 1'b0);
    rst_n = 1'b0;
    @(negedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R11 chrdy after reset", int'(chrdy), 1);
    check("R11 ctr_sel after reset", int'(ctr_sel), 0);
    finish_run();
  end
endmodule